// File: doc/BRIEF.md
# Ping-Pong Fully-Connected Layer Scheduler

This block sequences one fully-connected neural-network layer across up to sixteen neurons. The neurons are split into groups of eight multiply-accumulate lanes. Each neuron keeps sixteen weights of its own, which cover one sixteen-point slice of the flattened input. For each slice the block works in three steps. It reads the weights for every active group from memory, one 128-bit word (eight 16-bit values) per cycle. It then reads the slice's input values separately for each group into one half of a two-entry input buffer. Each read of inputs for the next group happens while the current group is computing on the other half of the buffer. When all slices are consumed, the block fetches one bias word per group and adds it to the accumulators. It then streams the neuron results out in index order.

The controller is a state machine with seven named states:

- IDLE waits for `start`, captures the configuration and clears the accumulators. It then goes to WLOAD.
- WLOAD issues all weight reads for the current slice. After the last one it goes to XLOAD.
- XLOAD issues the two input reads for the first group. It then goes to MAC.
- MAC counts the compute window of b cycles and adds the group's dot products on the window's last cycle. During the window's first two cycles it also reads the next group's inputs, when there is a next group. When the window ends, MAC does one of three things:
  - It stays in MAC for the next group.
  - It returns to WLOAD for the next slice.
  - It goes to BIAS after the final slice.
- BIAS issues one bias read per group. It then goes to BWAIT.
- BWAIT lets the last bias word land. It then goes to EMIT.
- EMIT presents one result per cycle. It returns to IDLE with `done` on the last result.

Memory read data is expected on `mem_rdata` one cycle after the read is issued.

Top module: `fc_pingpong_top`

## Requirements
- R1: After reset, and at any time the block is idle, `busy`, `mem_rd`, `res_valid` and `done` are low and `lane_sel` is zero.
- R2: The result of neuron j is the sum, over every input point p of the run, of weight(j,p) times input(p), plus the bias of j. All operands are signed 16-bit. The sum is kept in 32 bits and wraps modulo 2^32.
- R3: Memory layout:
  - `mem_sel` = 0 reads weights. Weight index w of slice s for group g sits at word address (s*G+g)*16+w, where G is the number of active groups. Neuron g*8+L takes bits [16L+15:16L].
  - `mem_sel` = 1 reads inputs. Word s*2+h holds input point s*16+h*8+i in bits [16i+15:16i].
  - `mem_sel` = 2 reads biases. Word g holds the bias of neuron g*8+L in bits [16L+15:16L].
- R4: A run with S slices issues exactly S*18*G+G reads. No input read of slice s is issued before all (s+1)*16*G weight reads up to and including slice s have been issued.
- R5: The loads overlap with computation. Counting the cycles in which `busy` is high, up to and including the cycle in which `done` is high, a run takes exactly S*(16*G+2+G*b) + G + 1 + n cycles.
- R6: `lane_sel` marks the neurons currently computing. At most 8 of its bits are set, all of them in one group, and never a bit at or above n. Over a run every neuron below n is marked at least once.
- R7: Results appear on consecutive cycles with `res_idx` counting 0 to n-1. `done` is high only together with the last result.
- R8: When n is 8 or less, only one group is scheduled, so G is 1 in R4 and R5. Lanes at or above n are masked and take no bias or products.
- R9: Out-of-range configuration values are clamped when captured:
  - b below 2 runs as 2.
  - n of 0 runs as 1, and n above 16 runs as 16.
  - S of 0 runs as 1, and S above 64 runs as 64.
- R10: `start` and the configuration inputs are ignored while `busy` is high. A run's results, read count and length depend only on the values captured when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| cfg_neurons | input | 5 | Neuron count n (1 to 16) |
| cfg_slices | input | 7 | Number S of sixteen-point input slices (1 to 64) |
| cfg_mac_cyc | input | 8 | Compute window b in cycles |
| busy | output | 1 | A run is in progress |
| lane_sel | output | 16 | Neuron-select register: neurons computing this cycle |
| mem_rd | output | 1 | Memory read request |
| mem_sel | output | 2 | Region: 0 weights, 1 inputs, 2 biases |
| mem_addr | output | 11 | Word address within the region |
| mem_rdata | input | 128 | Read data, valid one cycle after `mem_rd` |
| res_valid | output | 1 | `res_idx`/`res_value` hold a result |
| res_idx | output | 4 | Neuron index of the result |
| res_value | output | 32 | Signed neuron result |
| done | output | 1 | Last result of the run |

## Verification
Full-range random weights, inputs and biases, across random n, S and b, check the dot-product sums against a bench model. These runs separate correct operand addressing from swapped lanes, slices or buffer halves. A run of extreme operands in which every weight is -32768 and every input is 32767 forces the 32-bit sum to wrap, which a narrower or saturating accumulator would not match. Directed runs cover four cases:
- n=1, n=8 and n=9 distinguish group masking from full-group scheduling.
- b of 0 exposes the clamp through the run length.
- A run with n=16 shows the two-group overlap in its cycle count.
- A start pulse with altered configuration mid-run must leave the results and timing unchanged.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WLOAD,
        S_XLOAD,
        S_MAC,
        S_BIAS,
        S_BWAIT,
        S_EMIT
    } fc_state_e;

    typedef enum logic [1:0] {
        K_WGT  = 2'd0,
        K_INP  = 2'd1,
        K_BIAS = 2'd2
    } fc_kind_e;

endpackage

// File: rtl/fc_dot.sv
module fc_dot #(
    parameter int N    = 16,
    parameter int DW   = 16,
    parameter int ACCW = 32
) (
    input  logic [N*DW-1:0]       w_vec,
    input  logic [N*DW-1:0]       x_vec,
    output logic signed [ACCW-1:0] dot
);

    always_comb begin
        logic signed [ACCW-1:0] sum;
        sum = '0;
        for (int i = 0; i < N; i++) begin
            logic signed [2*DW-1:0] prod;
            prod = $signed(w_vec[i*DW +: DW]) * $signed(x_vec[i*DW +: DW]);
            sum  = sum + ACCW'(prod);
        end
        dot = sum;
    end

endmodule

// File: rtl/fc_lane_bank.sv
module fc_lane_bank
    import fc_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int GROUPS = 2,
    parameter int WPN    = 16,
    parameter int DW     = 16,
    parameter int ACCW   = 32,
    parameter int NEUR   = LANES * GROUPS,
    parameter int NW     = $clog2(NEUR + 1),
    parameter int IW     = $clog2(NEUR),
    parameter int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    parameter int WIW    = $clog2(WPN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [NW-1:0]           n_act,
    input  logic                    ld_vld,
    input  fc_kind_e                ld_kind,
    input  logic [GW-1:0]           ld_grp,
    input  logic [WIW-1:0]          ld_idx,
    input  logic                    ld_buf,
    input  logic [LANES*DW-1:0]     rdata,
    input  logic                    mac_en,
    input  logic [GW-1:0]           mac_grp,
    input  logic                    mac_buf,
    input  logic [IW-1:0]           rd_idx,
    output logic [ACCW-1:0]         rd_value
);

    logic signed [DW-1:0]   wgt  [NEUR][WPN];
    logic signed [DW-1:0]   xbuf [2][WPN];
    logic signed [ACCW-1:0] acc  [NEUR];
    logic signed [ACCW-1:0] dot  [LANES];
    logic [WPN*DW-1:0]      xv;

    always_comb begin
        for (int i = 0; i < WPN; i++) xv[i*DW +: DW] = xbuf[mac_buf][i];
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [WPN*DW-1:0]      wv;
        logic signed [ACCW-1:0] d;
        always_comb begin
            for (int i = 0; i < WPN; i++) wv[i*DW +: DW] = wgt[int'(mac_grp)*LANES + L][i];
        end
        fc_dot #(.N(WPN), .DW(DW), .ACCW(ACCW)) u_dot (.w_vec(wv), .x_vec(xv), .dot(d));
        assign dot[L] = d;
    end

    // operand storage: filled from the delayed load tag
    always_ff @(posedge clk) begin
        if (ld_vld && ld_kind == K_WGT) begin
            for (int L = 0; L < LANES; L++)
                wgt[int'(ld_grp)*LANES + L][ld_idx] <= rdata[L*DW +: DW];
        end else if (ld_vld && ld_kind == K_INP) begin
            for (int i = 0; i < LANES; i++)
                xbuf[ld_buf][int'(ld_idx)*LANES + i] <= rdata[i*DW +: DW];
        end
    end

    // accumulators: masked lanes never change
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < NEUR; k++) acc[k] <= '0;
        end else if (ld_vld && ld_kind == K_BIAS) begin
            for (int L = 0; L < LANES; L++) begin
                if (int'(ld_grp)*LANES + L < int'(n_act))
                    acc[int'(ld_grp)*LANES + L] <= acc[int'(ld_grp)*LANES + L]
                                                   + ACCW'($signed(rdata[L*DW +: DW]));
            end
        end else if (mac_en) begin
            for (int L = 0; L < LANES; L++) begin
                if (int'(mac_grp)*LANES + L < int'(n_act))
                    acc[int'(mac_grp)*LANES + L] <= acc[int'(mac_grp)*LANES + L] + dot[L];
            end
        end
    end

    assign rd_value = acc[rd_idx];

endmodule

// File: rtl/fc_sched_ctrl.sv
module fc_sched_ctrl
    import fc_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int GROUPS     = 2,
    parameter int WPN        = 16,
    parameter int MAX_SLICES = 64,
    parameter int MACW       = 8,
    parameter int NEUR       = LANES * GROUPS,
    parameter int NW         = $clog2(NEUR + 1),
    parameter int IW         = $clog2(NEUR),
    parameter int SW         = $clog2(MAX_SLICES + 1),
    parameter int GW         = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    parameter int WIW        = $clog2(WPN),
    parameter int AW         = $clog2(MAX_SLICES * GROUPS * WPN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NW-1:0]     cfg_neurons,
    input  logic [SW-1:0]     cfg_slices,
    input  logic [MACW-1:0]   cfg_mac_cyc,
    output logic              mem_rd,
    output logic [1:0]        mem_sel,
    output logic [AW-1:0]     mem_addr,
    output logic              ld_vld,
    output fc_kind_e          ld_kind,
    output logic [GW-1:0]     ld_grp,
    output logic [WIW-1:0]    ld_idx,
    output logic              ld_buf,
    output logic              mac_en,
    output logic [GW-1:0]     mac_grp,
    output logic              mac_buf,
    output logic              clr,
    output logic [NW-1:0]     n_act,
    output logic              busy,
    output logic [NEUR-1:0]   lane_sel,
    output logic              res_valid,
    output logic [IW-1:0]     res_idx,
    output logic              done
);

    localparam int HALVES = WPN / LANES;
    localparam int WCW    = $clog2(GROUPS * WPN) + 1;
    localparam int GC     = GW + 1;

    fc_state_e        st_q, st_d;
    logic [NW-1:0]    n_q;
    logic [SW-1:0]    ns_q, slc_q;
    logic [MACW-1:0]  b_q, ccnt_q;
    logic [GC-1:0]    ng_q, grp_q, bcnt_q;
    logic [WCW-1:0]   wcnt_q;
    logic [WIW-1:0]   half_q;
    logic             buf_q;
    logic [IW-1:0]    ocnt_q;

    logic             iss;
    fc_kind_e         iss_kind;
    logic [GW-1:0]    iss_grp;
    logic [WIW-1:0]   iss_idx;
    logic             iss_buf;

    logic w_last, x_last, mac_last, more_grp, more_slc, b_last, o_last;
    logic [NW-1:0]    n_cap;
    logic [SW-1:0]    s_cap;

    assign w_last   = (wcnt_q == WCW'(int'(ng_q) * WPN - 1));
    assign x_last   = (half_q == WIW'(HALVES - 1));
    assign mac_last = (ccnt_q == b_q - 1'b1);
    assign more_grp = (grp_q + 1'b1 < ng_q);
    assign more_slc = (slc_q + 1'b1 < ns_q);
    assign b_last   = (bcnt_q + 1'b1 == ng_q);
    assign o_last   = (NW'(ocnt_q) == n_q - 1'b1);

    assign n_cap = (cfg_neurons == '0) ? NW'(1) :
                   (int'(cfg_neurons) > NEUR) ? NW'(NEUR) : cfg_neurons;
    assign s_cap = (cfg_slices == '0) ? SW'(1) :
                   (int'(cfg_slices) > MAX_SLICES) ? SW'(MAX_SLICES) : cfg_slices;

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start) st_d = S_WLOAD;
            S_WLOAD: if (w_last) st_d = S_XLOAD;
            S_XLOAD: if (x_last) st_d = S_MAC;
            S_MAC: begin
                if (mac_last) begin
                    if (more_grp)      st_d = S_MAC;
                    else if (more_slc) st_d = S_WLOAD;
                    else               st_d = S_BIAS;
                end
            end
            S_BIAS:  if (b_last) st_d = S_BWAIT;
            S_BWAIT: st_d = S_EMIT;
            S_EMIT:  if (o_last) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            n_q <= NW'(1); ns_q <= SW'(1); b_q <= MACW'(HALVES); ng_q <= GC'(1);
            slc_q <= '0; wcnt_q <= '0; half_q <= '0; grp_q <= '0; buf_q <= 1'b0;
            ccnt_q <= '0; bcnt_q <= '0; ocnt_q <= '0;
            ld_vld <= 1'b0; ld_kind <= K_WGT; ld_grp <= '0; ld_idx <= '0; ld_buf <= 1'b0;
        end else begin
            st_q    <= st_d;
            ld_vld  <= iss;
            ld_kind <= iss_kind;
            ld_grp  <= iss_grp;
            ld_idx  <= iss_idx;
            ld_buf  <= iss_buf;
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        n_q    <= n_cap;
                        ns_q   <= s_cap;
                        b_q    <= (int'(cfg_mac_cyc) < HALVES) ? MACW'(HALVES) : cfg_mac_cyc;
                        ng_q   <= GC'((int'(n_cap) + LANES - 1) / LANES);
                        slc_q  <= '0;
                        wcnt_q <= '0;
                    end
                end
                S_WLOAD: begin
                    if (w_last) begin
                        wcnt_q <= '0; half_q <= '0; grp_q <= '0; buf_q <= 1'b0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                S_XLOAD: begin
                    if (x_last) ccnt_q <= '0;
                    else        half_q <= half_q + 1'b1;
                end
                S_MAC: begin
                    if (mac_last) begin
                        ccnt_q <= '0;
                        if (more_grp) begin
                            grp_q <= grp_q + 1'b1;
                            buf_q <= ~buf_q;
                        end else if (more_slc) begin
                            slc_q  <= slc_q + 1'b1;
                            wcnt_q <= '0;
                        end else begin
                            bcnt_q <= '0;
                        end
                    end else begin
                        ccnt_q <= ccnt_q + 1'b1;
                    end
                end
                S_BIAS:  bcnt_q <= bcnt_q + 1'b1;
                S_BWAIT: ocnt_q <= '0;
                S_EMIT:  ocnt_q <= ocnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        iss = 1'b0; iss_kind = K_WGT; iss_grp = '0; iss_idx = '0; iss_buf = 1'b0;
        mem_addr = '0; mac_en = 1'b0; res_valid = 1'b0; done = 1'b0;
        lane_sel = '0;
        clr = (st_q == S_IDLE) && start;
        unique case (st_q)
            S_WLOAD: begin
                iss      = 1'b1;
                iss_kind = K_WGT;
                iss_grp  = GW'(int'(wcnt_q) / WPN);
                iss_idx  = WIW'(int'(wcnt_q) % WPN);
                mem_addr = AW'(int'(slc_q) * int'(ng_q) * WPN + int'(wcnt_q));
            end
            S_XLOAD: begin
                iss      = 1'b1;
                iss_kind = K_INP;
                iss_idx  = half_q;
                iss_buf  = buf_q;
                mem_addr = AW'(int'(slc_q) * HALVES + int'(half_q));
            end
            S_MAC: begin
                for (int j = 0; j < NEUR; j++)
                    lane_sel[j] = (j / LANES == int'(grp_q)) && (j < int'(n_q));
                if (int'(ccnt_q) < HALVES && more_grp) begin
                    iss      = 1'b1;
                    iss_kind = K_INP;
                    iss_idx  = WIW'(ccnt_q);
                    iss_buf  = ~buf_q;
                    mem_addr = AW'(int'(slc_q) * HALVES + int'(ccnt_q));
                end
                mac_en = mac_last;
            end
            S_BIAS: begin
                iss      = 1'b1;
                iss_kind = K_BIAS;
                iss_grp  = GW'(bcnt_q);
                mem_addr = AW'(bcnt_q);
            end
            S_EMIT: begin
                res_valid = 1'b1;
                done      = o_last;
            end
            default: ;
        endcase
    end

    assign mem_rd  = iss;
    assign mem_sel = iss_kind;
    assign mac_grp = GW'(grp_q);
    assign mac_buf = buf_q;
    assign n_act   = n_q;
    assign busy    = (st_q != S_IDLE);
    assign res_idx = ocnt_q;

endmodule

// File: rtl/fc_pingpong_top.sv
module fc_pingpong_top
    import fc_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int GROUPS     = 2,
    parameter int WPN        = 16,
    parameter int DW         = 16,
    parameter int ACCW       = 32,
    parameter int MAX_SLICES = 64,
    parameter int MACW       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(LANES*GROUPS+1)-1:0] cfg_neurons,
    input  logic [$clog2(MAX_SLICES+1)-1:0]   cfg_slices,
    input  logic [MACW-1:0]               cfg_mac_cyc,
    output logic                          busy,
    output logic [LANES*GROUPS-1:0]       lane_sel,
    output logic                          mem_rd,
    output logic [1:0]                    mem_sel,
    output logic [$clog2(MAX_SLICES*GROUPS*WPN)-1:0] mem_addr,
    input  logic [LANES*DW-1:0]           mem_rdata,
    output logic                          res_valid,
    output logic [$clog2(LANES*GROUPS)-1:0] res_idx,
    output logic [ACCW-1:0]               res_value,
    output logic                          done
);

    localparam int NEUR = LANES * GROUPS;
    localparam int NW   = $clog2(NEUR + 1);
    localparam int IW   = $clog2(NEUR);
    localparam int SW   = $clog2(MAX_SLICES + 1);
    localparam int GW   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int WIW  = $clog2(WPN);
    localparam int AW   = $clog2(MAX_SLICES * GROUPS * WPN);

    logic             ld_vld, ld_buf, mac_en, mac_buf, clr;
    fc_kind_e         ld_kind;
    logic [GW-1:0]    ld_grp, mac_grp;
    logic [WIW-1:0]   ld_idx;
    logic [NW-1:0]    n_act;

    fc_sched_ctrl #(
        .LANES(LANES), .GROUPS(GROUPS), .WPN(WPN), .MAX_SLICES(MAX_SLICES), .MACW(MACW),
        .NEUR(NEUR), .NW(NW), .IW(IW), .SW(SW), .GW(GW), .WIW(WIW), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_neurons(cfg_neurons), .cfg_slices(cfg_slices), .cfg_mac_cyc(cfg_mac_cyc),
        .mem_rd(mem_rd), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .ld_vld(ld_vld), .ld_kind(ld_kind), .ld_grp(ld_grp), .ld_idx(ld_idx), .ld_buf(ld_buf),
        .mac_en(mac_en), .mac_grp(mac_grp), .mac_buf(mac_buf),
        .clr(clr), .n_act(n_act), .busy(busy), .lane_sel(lane_sel),
        .res_valid(res_valid), .res_idx(res_idx), .done(done)
    );

    fc_lane_bank #(
        .LANES(LANES), .GROUPS(GROUPS), .WPN(WPN), .DW(DW), .ACCW(ACCW),
        .NEUR(NEUR), .NW(NW), .IW(IW), .GW(GW), .WIW(WIW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .n_act(n_act),
        .ld_vld(ld_vld), .ld_kind(ld_kind), .ld_grp(ld_grp), .ld_idx(ld_idx), .ld_buf(ld_buf),
        .rdata(mem_rdata), .mac_en(mac_en), .mac_grp(mac_grp), .mac_buf(mac_buf),
        .rd_idx(res_idx), .rd_value(res_value)
    );

endmodule

// File: rtl/fc_sched_chk.sv
module fc_sched_chk #(
    parameter int LANES = 8,
    parameter int NEUR  = 16,
    parameter int IW    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            mem_rd,
    input logic [NEUR-1:0] lane_sel,
    input logic            res_valid,
    input logic [IW-1:0]   res_idx,
    input logic            done
);

    // R1: idle block is quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && lane_sel == '0 && !res_valid && !done));

    // R6: never more than one group of lanes selected
    a_r6_sel_width: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_sel) <= LANES);

    // R7: done only with a result
    a_r7_done_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);

    // R7: consecutive results count up by one
    a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid)) |-> (res_idx == $past(res_idx) + 1'b1));

    // R7: result stream stops after done
    a_r7_stop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !res_valid);

    // R10: an accepted start makes the block busy
    a_r10_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind fc_pingpong_top fc_sched_chk #(.LANES(LANES), .NEUR(NEUR), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_rd(mem_rd),
    .lane_sel(lane_sel), .res_valid(res_valid), .res_idx(res_idx), .done(done)
);

// File: tb/sim_fc_pingpong_top.sv
module sim_fc_pingpong_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [4:0]   cfg_neurons = 5'd1;
    logic [6:0]   cfg_slices = 7'd1;
    logic [7:0]   cfg_mac_cyc = 8'd2;
    logic         busy, mem_rd, res_valid, done;
    logic [15:0]  lane_sel;
    logic [1:0]   mem_sel;
    logic [10:0]  mem_addr;
    logic [127:0] mem_rdata = '0;
    logic [3:0]   res_idx;
    logic [31:0]  res_value;

    logic [127:0] wmem [0:2047];
    logic [127:0] xmem [0:127];
    logic [127:0] bmem [0:1];

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fc_pingpong_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_neurons(cfg_neurons),
        .cfg_slices(cfg_slices), .cfg_mac_cyc(cfg_mac_cyc), .busy(busy),
        .lane_sel(lane_sel), .mem_rd(mem_rd), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .res_valid(res_valid), .res_idx(res_idx),
        .res_value(res_value), .done(done)
    );

    // memory responder: data one cycle after the request (R3)
    initial begin
        forever begin
            @(posedge clk);
            if (mem_rd) begin
                case (mem_sel)
                    2'd0:    mem_rdata <= wmem[mem_addr];
                    2'd1:    mem_rdata <= xmem[mem_addr[6:0]];
                    2'd2:    mem_rdata <= bmem[mem_addr[0]];
                    default: mem_rdata <= '0;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int ns, input int ng, input int mode);
        for (int a = 0; a < ns * ng * 16; a++)
            wmem[a] = (mode == 1) ? {8{16'h8000}} : {$urandom, $urandom, $urandom, $urandom};
        for (int a = 0; a < ns * 2; a++)
            xmem[a] = (mode == 1) ? {8{16'h7fff}} : {$urandom, $urandom, $urandom, $urandom};
        for (int a = 0; a < 2; a++)
            bmem[a] = (mode == 1) ? {8{16'h8000}} : {$urandom, $urandom, $urandom, $urandom};
    endtask

    function automatic int exp_out(input int j, input int ns, input int ng);
        int acc = 0;
        int g = j / 8;
        int l = j % 8;
        for (int s = 0; s < ns; s++) begin
            for (int w = 0; w < 16; w++) begin
                logic signed [15:0] wv, xv;
                wv  = wmem[(s * ng + g) * 16 + w][16*l +: 16];
                xv  = xmem[s * 2 + w / 8][16*(w % 8) +: 16];
                acc = acc + int'(wv) * int'(xv);
            end
        end
        begin
            logic signed [15:0] bv;
            bv  = bmem[g][16*l +: 16];
            acc = acc + int'(bv);
        end
        return acc;
    endfunction

    task automatic run(input int n, input int ns, input int b, input bit poke, input int mode);
        int ng = (n + 7) / 8;
        int beff = (b < 2) ? 2 : b;
        int cyc = 0, reads = 0, wfetch = 0, got = 0;
        bit order_ok = 1'b1, sel_ok = 1'b1, seen_done = 1'b0;
        logic [15:0] allowed, sel_or;
        allowed = 16'((32'd1 << n) - 1);
        sel_or  = '0;
        fill(ns, ng, mode);
        cfg_neurons = 5'(n);
        cfg_slices  = 7'(ns);
        cfg_mac_cyc = 8'(b);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!seen_done && cyc < 60000) begin
            if (busy) cyc++;
            if (mem_rd) begin
                reads++;
                if (mem_sel == 2'd0) wfetch++;
                if (mem_sel == 2'd1 && wfetch != (int'(mem_addr) / 2 + 1) * 16 * ng) order_ok = 1'b0;
            end
            if ((lane_sel & ~allowed) != '0 || $countones(lane_sel) > 8) sel_ok = 1'b0;
            sel_or |= lane_sel;
            if (res_valid) begin
                chk(res_idx == 4'(got), "R7 result order", res_idx, got);
                chk($signed(res_value) == exp_out(got, ns, ng), "R2,R3 neuron value",
                    $signed(res_value), exp_out(got, ns, ng));
                got++;
            end
            if (done) seen_done = 1'b1;
            if (poke && cyc == 5) begin
                // R10: start and config changes while busy
                start = 1'b1; cfg_neurons = 5'd3; cfg_slices = 7'd9; cfg_mac_cyc = 8'd7;
            end else if (poke && cyc == 6) begin
                start = 1'b0; cfg_neurons = 5'(n); cfg_slices = 7'(ns); cfg_mac_cyc = 8'(b);
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen_done, "R7 done seen", seen_done, 1);
        chk(got == n, "R7 result count", got, n);
        chk(cyc == ns * (16 * ng + 2 + ng * beff) + ng + 1 + n,
            (b < 2) ? "R9 clamp run length" : (poke ? "R10 run length" : "R5 run length"),
            cyc, ns * (16 * ng + 2 + ng * beff) + ng + 1 + n);
        chk(reads == ns * 18 * ng + ng, (n <= 8) ? "R8 read count" : "R4 read count",
            reads, ns * 18 * ng + ng);
        chk(order_ok, "R4 weights before inputs", order_ok, 1);
        chk(sel_ok, "R6 lane_sel bound", sel_ok, 1);
        chk(sel_or == allowed, "R6 lane_sel coverage", sel_or, allowed);
        chk(!busy && !res_valid && !mem_rd, "R1 idle after run", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1 busy", busy, 0);
        chk(!mem_rd, "R1 mem_rd", mem_rd, 0);
        chk(lane_sel == '0, "R1 lane_sel", lane_sel, 0);
        chk(!res_valid && !done, "R1 result", res_valid, 0);

        run(16, 1, 2, 1'b0, 0);   // R5: two groups overlapped
        run(1, 1, 0, 1'b0, 0);    // R9: b clamp, R8: single lane
        run(8, 3, 5, 1'b0, 0);    // R8: full single group
        run(9, 2, 1, 1'b0, 0);    // R8 boundary, R9 clamp
        run(16, 2, 4, 1'b0, 1);   // R2 wrap with extreme operands
        run(5, 2, 3, 1'b1, 0);    // R10 ignored start
        for (int r = 0; r < 8; r++) begin
            int n = 1 + int'($urandom % 16);
            int s = 1 + int'($urandom % 4);
            int b = int'($urandom % 8);
            run(n, s, b, 1'b0, 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule